// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block sits between the interrupt arbiter of a processor core and the system bus. When the arbiter picks a request that belongs to an external, cascaded interrupt controller, the block runs two back-to-back acknowledge bus cycles. It pulses the address latch strobe at the start of each cycle and drives a dedicated active-low acknowledge line through the middle of each cycle. It reads the interrupt type byte from the low data lines during the second cycle and hands the type, with its vector table address, to the CPU side. A request marked non-maskable skips the bus entirely and returns the fixed type 02h.

Each cascaded channel owns a cascade enable bit. When that bit is set, a neighbouring interrupt pin stops acting as an input and carries the channel's acknowledge strobe instead. Channel 0 drives alternate pin 0, and channel 1 drives alternate pin 1. The request side and the result side are valid/ready streams. A request is taken only in a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low while a sequence runs and while a result waits. A result is held, unchanged, until `out_ready` is high on a clock edge where `out_valid` is high. The result port has no limit on how long it can stall.

Top module: `int_ack_seq`

## Requirements
- R1: A cascaded request produces two bus cycles made of the states T1, T2, T3, optional waits, and T4. `ale` is high for exactly the single T1 clock of each cycle, so it pulses twice per request.
- R2: Exactly two idle clocks separate the first T4 from the second T1. During these clocks `ale` is low and the acknowledge line is inactive.
- R3: `bus_ready` is sampled at the end of T3 and of every wait state. While it is low, wait clocks are added and the acknowledge line stays low.
- R4: `lock_n` is low continuously from the first T1 through the second T4, including the idle gap. It is high at all other times.
- R5: The type is taken from `bus_byte` on the clock edge that ends the last T3 or wait state of the second cycle. Data present during the first cycle has no effect on the result.
- R6: `rd_n` is high at all times.
- R7: The acknowledge strobe is active low from T2 up to T4, in both cycles. It appears only on `alt_ack_n[c]`, where c is the requesting channel, and only while `casc_en[c]` is 1. Every other alternate pin stays high.
- R8: `out_vector` equals `out_type` shifted left by two, a 10-bit value from 000h to 3FCh.
- R9: `out_valid` rises one clock after the second T4. The type and vector then stay stable until the `out_valid`/`out_ready` handshake. `req_ready` is low from acceptance until the clock after that handshake.
- R10: A request with `req_nmi` set performs no bus cycle: `ale` stays low and `lock_n` stays high. `out_valid` is high on the next clock with type 02h and vector 008h.
- R11: A request for a channel whose `casc_en` bit is 0, without `req_nmi`, is not accepted: `req_ready` is low and no bus activity starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| casc_en | input | 2 | Cascade enable per channel; turns the alternate pin into that channel's acknowledge output |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_chan | input | 1 | Channel of the winning request |
| req_nmi | input | 1 | Request is non-maskable; no bus cycles |
| bus_ready | input | 1 | Bus ready; low inserts wait states |
| bus_byte | input | 8 | Low byte of the data bus |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Read strobe, held inactive |
| lock_n | output | 1 | Bus lock, low across both cycles |
| alt_ack_n | output | 2 | Alternate pins carrying the acknowledge strobe |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_type | output | 8 | Captured interrupt type |
| out_vector | output | 10 | Vector table address (type × 4) |

## Verification
The result handshake and the next request can meet in the same clock. The retiring handshake frees the sequencer at the very edge where a new request is already waiting. The bench holds `req_valid` high through the handshake cycle. It then checks that the request is not taken on that edge, because `req_ready` was still low. It also checks that the request is taken on the following edge, with `ale` appearing one clock later and a correct type at the end. A second overlap comes from wait states in the second cycle, which move the capture edge. The bench changes `bus_byte` away from the true type right after the expected capture edge, so a capture that fires too early or too late returns the wrong type.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_T3,
    PH_TW,
    PH_T4,
    PH_GAP,
    PH_OUT
  } phase_e;
endpackage

// File: rtl/iack_phase_fsm.sv
module iack_phase_fsm
  import iack_pkg::*;
#(
  parameter int IDLE_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_nmi,
  input  logic bus_ready,
  input  logic out_ready,
  output logic idle,
  output logic ale,
  output logic ack_active,
  output logic lock_active,
  output logic cap_en,
  output logic out_valid
);
  localparam int GAP_W = (IDLE_GAP > 1) ? $clog2(IDLE_GAP) : 1;

  phase_e            ph_q, ph_d;
  logic              second_q, second_d;
  logic [GAP_W-1:0]  gap_q, gap_d;

  always_comb begin
    ph_d     = ph_q;
    second_d = second_q;
    gap_d    = gap_q;
    unique case (ph_q)
      PH_IDLE: begin
        second_d = 1'b0;
        if (start) ph_d = start_nmi ? PH_OUT : PH_T1;
      end
      PH_T1:   ph_d = PH_T2;
      PH_T2:   ph_d = PH_T3;
      PH_T3,
      PH_TW:   ph_d = bus_ready ? PH_T4 : PH_TW;
      PH_T4: begin
        if (second_q) begin
          ph_d = PH_OUT;
        end else begin
          second_d = 1'b1;
          gap_d    = '0;
          ph_d     = (IDLE_GAP == 0) ? PH_T1 : PH_GAP;
        end
      end
      PH_GAP: begin
        if (gap_q == GAP_W'(IDLE_GAP - 1)) ph_d = PH_T1;
        else gap_d = gap_q + 1'b1;
      end
      PH_OUT:  if (out_ready) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      second_q <= 1'b0;
      gap_q    <= '0;
    end else begin
      ph_q     <= ph_d;
      second_q <= second_d;
      gap_q    <= gap_d;
    end
  end

  assign idle        = (ph_q == PH_IDLE);
  assign ale         = (ph_q == PH_T1);
  assign ack_active  = (ph_q == PH_T2) || (ph_q == PH_T3) || (ph_q == PH_TW);
  assign lock_active = (ph_q != PH_IDLE) && (ph_q != PH_OUT);
  assign cap_en      = second_q && ((ph_q == PH_T3) || (ph_q == PH_TW)) && bus_ready;
  assign out_valid   = (ph_q == PH_OUT);

  assert_ale_then_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> ack_active);
  assert_ack_inside_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_active |-> lock_active);
  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  assert_nmi_no_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && start_nmi |=> out_valid && !lock_active);
endmodule

// File: rtl/iack_pin_route.sv
module iack_pin_route #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   start_chan,
  input  logic              ack_active,
  input  logic [NUM_CH-1:0] casc_en,
  output logic [NUM_CH-1:0] alt_ack_n
);
  logic [CH_W-1:0] chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chan_q <= '0;
    else if (start) chan_q <= start_chan;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
    assign alt_ack_n[i] = ~(ack_active && casc_en[i] && (chan_q == CH_W'(i)));

    assert_pin_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !alt_ack_n[i] |-> casc_en[i] && ack_active);
  end

  assert_single_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~alt_ack_n));
endmodule

// File: rtl/iack_type_cap.sv
module iack_type_cap #(
  parameter int              TYPE_W   = 8,
  parameter logic [TYPE_W-1:0] NMI_TYPE = 8'h02,
  parameter int              VEC_W    = TYPE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              nmi_load,
  input  logic [TYPE_W-1:0] bus_byte,
  input  logic              out_valid,
  input  logic              out_ready,
  output logic [TYPE_W-1:0] type_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [TYPE_W-1:0] type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        type_q <= '0;
    else if (nmi_load) type_q <= NMI_TYPE;
    else if (cap_en)   type_q <= bus_byte;
  end

  assign type_o = type_q;
  assign vec_o  = {type_q, 2'b00};

  assert_type_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(type_o));
  assert_no_load_while_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cap_en);
endmodule

// File: rtl/int_ack_seq.sv
module int_ack_seq #(
  parameter int NUM_CH   = 2,
  parameter int TYPE_W   = 8,
  parameter int IDLE_GAP = 2,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int VEC_W    = TYPE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] casc_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_chan,
  input  logic              req_nmi,
  input  logic              bus_ready,
  input  logic [TYPE_W-1:0] bus_byte,
  output logic              ale,
  output logic              rd_n,
  output logic              lock_n,
  output logic [NUM_CH-1:0] alt_ack_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TYPE_W-1:0] out_type,
  output logic [VEC_W-1:0]  out_vector
);
  logic idle, ack_active, lock_active, cap_en, start;

  assign req_ready = idle && (req_nmi || casc_en[req_chan]);
  assign start     = req_valid && req_ready;

  iack_phase_fsm #(.IDLE_GAP(IDLE_GAP)) u_fsm (
    .clk, .rst_n, .start, .start_nmi(req_nmi), .bus_ready, .out_ready,
    .idle, .ale, .ack_active, .lock_active, .cap_en, .out_valid
  );

  iack_pin_route #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_route (
    .clk, .rst_n, .start, .start_chan(req_chan), .ack_active, .casc_en, .alt_ack_n
  );

  iack_type_cap #(.TYPE_W(TYPE_W), .NMI_TYPE(TYPE_W'(2)), .VEC_W(VEC_W)) u_cap (
    .clk, .rst_n, .cap_en, .nmi_load(start && req_nmi), .bus_byte,
    .out_valid, .out_ready, .type_o(out_type), .vec_o(out_vector)
  );

  assign lock_n = ~lock_active;
  assign rd_n   = 1'b1;

  assert_busy_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n || out_valid) |-> !req_ready);
  assert_uncascaded_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_nmi && !casc_en[req_chan] |-> !req_ready);
endmodule

// File: tb/int_ack_seq_tb.sv
module int_ack_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] casc_en = 2'b11;
  logic       req_valid = 1'b0, req_chan = 1'b0, req_nmi = 1'b0;
  logic       req_ready;
  logic       bus_ready = 1'b1;
  logic [7:0] bus_byte = 8'h00;
  logic       ale, rd_n, lock_n, out_valid;
  logic       out_ready = 1'b0;
  logic [1:0] alt_ack_n;
  logic [7:0] out_type;
  logic [9:0] out_vector;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  int_ack_seq u_dut (
    .clk, .rst_n, .casc_en, .req_valid, .req_ready, .req_chan, .req_nmi,
    .bus_ready, .bus_byte, .ale, .rd_n, .lock_n, .alt_ack_n,
    .out_valid, .out_ready, .out_type, .out_vector
  );

  // {chan, nmi, wait1[4], wait2[4], data1[8], data2[8], stall[4]}
  localparam logic [29:0] VECS [6] = '{
    {1'b0, 1'b0, 4'd0, 4'd0, 8'h11, 8'hA5, 4'd0},
    {1'b1, 1'b0, 4'd0, 4'd0, 8'h22, 8'h3C, 4'd2},
    {1'b0, 1'b0, 4'd3, 4'd0, 8'h33, 8'hFF, 4'd0},
    {1'b1, 1'b0, 4'd0, 4'd4, 8'h44, 8'h00, 4'd1},
    {1'b0, 1'b1, 4'd0, 4'd0, 8'h00, 8'h00, 4'd1},
    {1'b1, 1'b0, 4'd2, 4'd2, 8'h55, 8'h81, 4'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_vec(input logic ch, input logic nmi, input int w1, input int w2,
                         input logic [7:0] d1, input logic [7:0] d2, input int stall);
    int last;
    logic [7:0] exp_t;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 idle ready", int'(req_ready), 1);
    req_valid = 1'b1; req_chan = ch; req_nmi = nmi;
    @(negedge clk);
    req_valid = 1'b0; req_nmi = 1'b0;
    last  = nmi ? 1 : 11 + w1 + w2;
    exp_t = nmi ? 8'h02 : d2;
    for (int k = 1; k < last; k++) begin
      bit e_ale, e_ack, e_lock;
      e_ale  = (k == 1) || (k == 7 + w1);
      e_ack  = (k >= 2 && k <= 3 + w1) || (k >= 8 + w1 && k <= 9 + w1 + w2);
      e_lock = (k <= 10 + w1 + w2);
      chk(ale == e_ale, "R1 ale", int'(ale), int'(e_ale));
      chk(alt_ack_n[ch] == !e_ack, "R7/R2/R3 ack pin", int'(alt_ack_n[ch]), int'(!e_ack));
      chk(alt_ack_n[!ch] == 1'b1, "R7 other pin", int'(alt_ack_n[!ch]), 1);
      chk(lock_n == !e_lock, "R4 lock", int'(lock_n), int'(!e_lock));
      chk(rd_n == 1'b1 && out_valid == 1'b0 && req_ready == 1'b0, "R6/R9 rd busy",
          int'({rd_n, out_valid, req_ready}), 4);
      bus_ready = !((k >= 3 && k <= 2 + w1) || (k >= 9 + w1 && k <= 8 + w1 + w2));
      bus_byte  = (k < 7 + w1) ? d1 : (k <= 9 + w1 + w2) ? d2 : 8'hEE;
      @(negedge clk);
    end
    bus_ready = 1'b1; bus_byte = 8'hEE;
    chk(out_valid == 1'b1, "R9 out_valid timing", int'(out_valid), 1);
    chk(out_type == exp_t, nmi ? "R10 nmi type" : "R5 type", int'(out_type), int'(exp_t));
    chk(out_vector == {exp_t, 2'b00}, "R8 vector", int'(out_vector), int'({exp_t, 2'b00}));
    if (nmi) chk(lock_n == 1'b1 && ale == 1'b0, "R10 no bus", int'({lock_n, ale}), 2);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid == 1'b1 && out_type == exp_t && req_ready == 1'b0, "R9 hold",
          int'(out_type), int'(exp_t));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && req_ready == 1'b1, "R9 retire", int'({out_valid, req_ready}), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && out_valid == 1'b0 && ale == 1'b0, "R9 reset outputs",
        int'({req_ready, out_valid, ale}), 4);
    chk(lock_n == 1'b1 && rd_n == 1'b1 && alt_ack_n == 2'b11, "R4/R6/R7 reset pins",
        int'({lock_n, rd_n, alt_ack_n}), 15);
    rst_n = 1'b1;
    foreach (VECS[i]) begin
      logic [29:0] v;
      v = VECS[i];
      run_vec(v[29], v[28], int'(v[27:24]), int'(v[23:20]), v[19:12], v[11:4], int'(v[3:0]));
    end

    // R11: channel 1 refused while its cascade bit is clear
    casc_en = 2'b01;
    @(negedge clk);
    req_valid = 1'b1; req_chan = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(req_ready == 1'b0 && ale == 1'b0 && lock_n == 1'b1 && alt_ack_n == 2'b11,
          "R11 refused", int'({req_ready, ale, lock_n, alt_ack_n}), 7);
    end
    req_valid = 1'b0;
    casc_en = 2'b11;

    // R9: request waiting across the result handshake
    run_vec(1'b0, 1'b0, 0, 0, 8'h01, 8'h5A, 0);
    @(negedge clk);
    req_valid = 1'b1; req_chan = 1'b0;
    @(negedge clk);
    bus_byte = 8'h6B;
    for (int k = 0; k < 30 && !out_valid; k++) @(negedge clk);
    chk(out_valid == 1'b1, "R9 pre-handshake valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(req_ready == 1'b1 && ale == 1'b0, "R9 not taken at handshake edge",
        int'({req_ready, ale}), 2);
    @(negedge clk);
    req_valid = 1'b0;
    chk(ale == 1'b1 && lock_n == 1'b0, "R1 taken one edge later", int'({ale, lock_n}), 2);
    for (int k = 0; k < 30 && !out_valid; k++) @(negedge clk);
    chk(out_type == 8'h6B && out_vector == 10'h1AC, "R5/R8 back-to-back type",
        int'(out_type), 'h6B);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule